// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This controller decides when a battery-backed memory may be accessed while its supply moves. It takes two raw supply-status flags from analog comparators: one that says the supply sits at or below the deselect window, and one that says it is below the battery switchover level. It also takes a free-running timebase pulse. From these it drives an internal deselect signal and a battery-select signal. It also gates the host bus strobes, so that a deselected memory neither drives its data pins nor accepts a write.

Protection is asymmetric. A qualified low-supply flag deselects the memory at the next clock. Release, however, waits a programmable number of timebase ticks after both flags have cleared, and any new dip during that wait starts the wait again. The battery is selected only while the switchover flag is qualified. When the supply collapses fast, so that the switchover flag appears almost together with deselect, the battery switch is held off for a minimum number of ticks. Both flags pass through a synchronizer and a stability filter before the state machine acts on them.

Top module: `pwr_guard_seq`

## Requirements
- R1: While reset is active and right after it is released, `deselect_o` is 1 and `batt_sel_o` is 0. The block returns to normal access only after REC_TICKS timebase ticks have passed with both supply flags clear.
- R2: Each supply flag passes through two synchronizer flops and then a filter. A new level must be seen for FILT_CYC consecutive cycles before it is acted on. A raw pulse shorter than FILT_CYC cycles has no effect on any output. A level held long enough changes the state seven cycles after it is applied (FILT_CYC = 4).
- R3: In normal access, a qualified low-supply flag sets `deselect_o` at the next clock edge.
- R4: While `deselect_o` is 1, `mem_cs_o`, `mem_we_o` and `dq_oe_o` are all 0, whatever the values of `bus_cs_i`, `bus_we_i` and `bus_oe_i`.
- R5: While `deselect_o` is 0, the strobes pass through: `mem_cs_o` = cs, `mem_we_o` = cs & we, and `dq_oe_o` = cs & oe & ~we. All bus strobes are active high.
- R6: A qualified switchover flag in the deselected state sets `batt_sel_o` once at least FAST_TICKS ticks have been counted since deselect began. After a fast collapse it therefore rises FAST_TICKS+1 cycles after deselect with a tick every cycle. After a slow collapse it rises one cycle after the flag qualifies.
- R7: When the switchover flag clears, `batt_sel_o` drops at the next edge. If the low-supply flag is still set, `deselect_o` stays 1.
- R8: Once both flags are clear, the block stays deselected until REC_TICKS ticks have been counted. It does not advance in cycles without a tick.
- R9: A qualified flag during the recovery wait returns the block to the deselected state. The full REC_TICKS count then restarts after the flags clear again.
- R10: A qualified switchover flag alone, with the low-supply flag clear, also deselects the memory from normal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sup_low_i | input | 1 | Raw flag: supply at or below the deselect window |
| sup_crit_i | input | 1 | Raw flag: supply below the battery switchover level |
| tick_i | input | 1 | Timebase pulse, one cycle wide |
| bus_cs_i | input | 1 | Host chip select, active high |
| bus_we_i | input | 1 | Host write strobe, active high |
| bus_oe_i | input | 1 | Host output enable, active high |
| deselect_o | output | 1 | Memory deselected and write protected |
| batt_sel_o | output | 1 | Power the memory from the battery |
| mem_cs_o | output | 1 | Gated chip select to the array |
| mem_we_o | output | 1 | Gated write strobe to the array |
| dq_oe_o | output | 1 | Data pin driver enable; 0 means high impedance |

## Verification
The supply flags are driven through five situations: a sub-threshold glitch, a slow fall in which the switchover flag arrives long after deselect, a fast fall in which only the switchover flag rises, a recovery with the timebase paused, and a dip during recovery. The glitch tells the filter apart from a bare synchronizer. The slow and fast falls tell the battery hold-off apart from an immediate switch. The paused timebase shows that recovery counts ticks and not cycles. The dip tells a restarting recovery count from one that resumes. Read, write and idle strobe patterns are applied across deselected and normal phases, which shows the gating both in its blocking and in its pass-through behaviour.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_DESEL  = 2'd1,
    ST_BATT   = 2'd2,
    ST_RECOV  = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pg_flag_qual.sv
module pg_flag_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= 1'b0;
      cnt_q <= '0;
    end else if (s != q_o) begin
      if (cnt_q == CW'(FILT_CYC - 1)) begin
        q_o   <= s;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  generate
    if (FILT_CYC >= 2) begin : g_filt_chk
      // R2
      filt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_o != $past(q_o)) |-> ($past(s, 2) == q_o));
    end
  endgenerate
endmodule

// File: rtl/pg_seq_fsm.sv
module pg_seq_fsm
  import pwr_guard_pkg::*;
#(
  parameter int unsigned REC_TICKS  = 40,
  parameter int unsigned FAST_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_q_i,
  input  logic crit_q_i,
  input  logic tick_i,
  output logic deselect_o,
  output logic batt_sel_o
);
  localparam int unsigned RW = $clog2(REC_TICKS + 1);
  localparam int unsigned FW = $clog2(FAST_TICKS + 2);
  localparam logic [FW-1:0] FAST_MAX = FW'(FAST_TICKS);
  localparam logic [RW-1:0] REC_LAST = RW'(REC_TICKS - 1);

  pg_state_e     state_q, state_d;
  logic [RW-1:0] tmr_q, tmr_d;
  logic [FW-1:0] dwell_q, dwell_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    dwell_d = dwell_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (low_q_i || crit_q_i) begin
          state_d = ST_DESEL;
          dwell_d = '0;
        end
      end
      ST_DESEL: begin
        if (tick_i && dwell_q != FAST_MAX) dwell_d = dwell_q + 1'b1;
        if (crit_q_i) begin
          if (dwell_q == FAST_MAX) state_d = ST_BATT;
        end else if (!low_q_i) begin
          state_d = ST_RECOV;
          tmr_d   = '0;
        end
      end
      ST_BATT: begin
        if (!crit_q_i) begin
          if (low_q_i) begin
            state_d = ST_DESEL;
            dwell_d = FAST_MAX;
          end else begin
            state_d = ST_RECOV;
            tmr_d   = '0;
          end
        end
      end
      ST_RECOV: begin
        if (low_q_i || crit_q_i) begin
          state_d = ST_DESEL;
          dwell_d = '0;
        end else if (tick_i) begin
          if (tmr_q == REC_LAST) state_d = ST_NORMAL;
          else                   tmr_d   = tmr_q + 1'b1;
        end
      end
      default: state_d = ST_DESEL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RECOV;
      tmr_q   <= '0;
      dwell_q <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      dwell_q <= dwell_d;
    end
  end

  assign deselect_o = (state_q != ST_NORMAL);
  assign batt_sel_o = (state_q == ST_BATT);

  // R3
  low_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL && low_q_i) |=> deselect_o);
  // R10
  crit_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL && crit_q_i) |=> deselect_o);
  // R6
  batt_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DESEL && dwell_q != FAST_MAX) |=> !batt_sel_o);
  // R9
  recov_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV && (low_q_i || crit_q_i)) |=> (state_q == ST_DESEL));
  // R8
  release_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(deselect_o) |-> (!$past(low_q_i) && !$past(crit_q_i) && $past(tick_i)));
endmodule

// File: rtl/pg_bus_gate.sv
module pg_bus_gate (
  input  logic deselect_i,
  input  logic cs_i,
  input  logic we_i,
  input  logic oe_i,
  output logic cs_o,
  output logic we_o,
  output logic oe_o
);
  logic open_access;

  assign open_access = cs_i & ~deselect_i;
  assign cs_o = open_access;
  assign we_o = open_access & we_i;
  assign oe_o = open_access & oe_i & ~we_i;
endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 4,
  parameter int unsigned REC_TICKS   = 40,
  parameter int unsigned FAST_TICKS  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_low_i,
  input  logic sup_crit_i,
  input  logic tick_i,
  input  logic bus_cs_i,
  input  logic bus_we_i,
  input  logic bus_oe_i,
  output logic deselect_o,
  output logic batt_sel_o,
  output logic mem_cs_o,
  output logic mem_we_o,
  output logic dq_oe_o
);
  localparam int unsigned NFLAG = 2;

  logic [NFLAG-1:0] raw_flags, q_flags;

  assign raw_flags = {sup_crit_i, sup_low_i};

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_qual
      pg_flag_qual #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_CYC   (FILT_CYC)
      ) u_qual (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .raw_i (raw_flags[i]),
        .q_o   (q_flags[i])
      );
    end
  endgenerate

  pg_seq_fsm #(
    .REC_TICKS (REC_TICKS),
    .FAST_TICKS(FAST_TICKS)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .low_q_i   (q_flags[0]),
    .crit_q_i  (q_flags[1]),
    .tick_i    (tick_i),
    .deselect_o(deselect_o),
    .batt_sel_o(batt_sel_o)
  );

  pg_bus_gate u_gate (
    .deselect_i(deselect_o),
    .cs_i      (bus_cs_i),
    .we_i      (bus_we_i),
    .oe_i      (bus_oe_i),
    .cs_o      (mem_cs_o),
    .we_o      (mem_we_o),
    .oe_o      (dq_oe_o)
  );

  // R4
  batt_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_sel_o |-> (!mem_we_o && !dq_oe_o && !mem_cs_o));
  // R4
  desel_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deselect_o |-> !dq_oe_o);
endmodule

// File: tb/pwr_guard_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_guard_seq_tb_top;
  localparam int unsigned REC   = 8;
  localparam int unsigned FAST  = 3;
  localparam int unsigned FILT  = 4;

  typedef struct {
    int    cyc;
    logic  desel;
    logic  batt;
    string tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sup_low_i = 1'b0, sup_crit_i = 1'b0, tick_i = 1'b1;
  logic bus_cs_i = 1'b1, bus_we_i = 1'b0, bus_oe_i = 1'b1;
  logic deselect_o, batt_sel_o, mem_cs_o, mem_we_o, dq_oe_o;

  int   cyc = 0;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pwr_guard_seq #(
    .SYNC_STAGES(2), .FILT_CYC(FILT), .REC_TICKS(REC), .FAST_TICKS(FAST)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sup_low_i(sup_low_i), .sup_crit_i(sup_crit_i),
    .tick_i(tick_i), .bus_cs_i(bus_cs_i), .bus_we_i(bus_we_i), .bus_oe_i(bus_oe_i),
    .deselect_o(deselect_o), .batt_sel_o(batt_sel_o), .mem_cs_o(mem_cs_o),
    .mem_we_o(mem_we_o), .dq_oe_o(dq_oe_o)
  );

  task automatic expect_at(input int c, input logic d, input logic b, input string tag);
    exp_t e;
    e.cyc = c; e.desel = d; e.batt = b; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  task automatic check1(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  // monitor: sample between negedge and next posedge
  always begin
    @(negedge clk_i);
    #1;
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      logic ecs, ewe, eoe;
      string btag;
      e = sb.pop_front();
      if (e.cyc < cyc) begin
        n_run++; n_fail++;
        $display("FAIL %s missed sample: actual cycle %0d expected cycle %0d", e.tag, cyc, e.cyc);
      end else begin
        check1(e.tag, "deselect_o", deselect_o, e.desel);
        check1(e.tag, "batt_sel_o", batt_sel_o, e.batt);
        ecs  = bus_cs_i & ~e.desel;
        ewe  = bus_cs_i & bus_we_i & ~e.desel;
        eoe  = bus_cs_i & bus_oe_i & ~bus_we_i & ~e.desel;
        btag = e.desel ? "R4" : "R5";
        check1(btag, "mem_cs_o", mem_cs_o, ecs);
        check1(btag, "mem_we_o", mem_we_o, ewe);
        check1(btag, "dq_oe_o", dq_oe_o, eoe);
      end
    end
  end

  initial begin
    @(negedge clk_i);
    // R1: reset and power-up recovery
    expect_at(1, 1'b1, 1'b0, "R1");
    expect_at(2, 1'b1, 1'b0, "R1");
    expect_at(9, 1'b1, 1'b0, "R1");
    expect_at(10, 1'b0, 1'b0, "R1");
    wait_cyc(2); rst_ni = 1'b1;

    // R2: 3-cycle glitch filtered
    expect_at(18, 1'b0, 1'b0, "R2");
    expect_at(20, 1'b0, 1'b0, "R2");
    expect_at(22, 1'b0, 1'b0, "R2");
    expect_at(24, 1'b0, 1'b0, "R2");
    wait_cyc(14); bus_we_i = 1'b1; bus_oe_i = 1'b0; sup_low_i = 1'b1;
    wait_cyc(17); sup_low_i = 1'b0;

    // R3: immediate deselect, then R6 slow collapse to battery, R7 release
    expect_at(36, 1'b0, 1'b0, "R3");
    expect_at(37, 1'b1, 1'b0, "R3");
    expect_at(56, 1'b1, 1'b0, "R6");
    expect_at(57, 1'b1, 1'b1, "R6");
    expect_at(76, 1'b1, 1'b1, "R7");
    expect_at(77, 1'b1, 1'b0, "R7");
    wait_cyc(30); sup_low_i = 1'b1;
    wait_cyc(50); sup_crit_i = 1'b1;
    wait_cyc(70); sup_crit_i = 1'b0;

    // R8: recovery counts ticks only
    expect_at(110, 1'b1, 1'b0, "R8");
    expect_at(127, 1'b1, 1'b0, "R8");
    expect_at(128, 1'b0, 1'b0, "R8");
    wait_cyc(90); sup_low_i = 1'b0;
    wait_cyc(92); tick_i = 1'b0;
    wait_cyc(120); tick_i = 1'b1;

    // R9: dip during recovery restarts the count
    expect_at(165, 1'b1, 1'b0, "R9");
    expect_at(176, 1'b1, 1'b0, "R9");
    expect_at(177, 1'b0, 1'b0, "R9");
    wait_cyc(140); sup_low_i = 1'b1;
    wait_cyc(150); sup_low_i = 1'b0;
    wait_cyc(157); sup_low_i = 1'b1;
    wait_cyc(162); sup_low_i = 1'b0;

    // R10: switchover flag alone; R6 fast-collapse hold-off; R4 strobes blocked
    expect_at(191, 1'b0, 1'b0, "R10");
    expect_at(192, 1'b1, 1'b0, "R10");
    expect_at(195, 1'b1, 1'b0, "R6");
    expect_at(196, 1'b1, 1'b1, "R6");
    expect_at(199, 1'b1, 1'b1, "R4");
    expect_at(206, 1'b1, 1'b1, "R7");
    expect_at(207, 1'b1, 1'b0, "R7");
    expect_at(214, 1'b1, 1'b0, "R8");
    expect_at(215, 1'b0, 1'b0, "R8");
    wait_cyc(180); bus_we_i = 1'b0; bus_oe_i = 1'b1;
    wait_cyc(185); sup_crit_i = 1'b1;
    wait_cyc(198); bus_we_i = 1'b1; bus_oe_i = 1'b0;
    wait_cyc(200); sup_crit_i = 1'b0;

    // R5: pass-through patterns in normal access
    expect_at(222, 1'b0, 1'b0, "R5");
    expect_at(226, 1'b0, 1'b0, "R5");
    wait_cyc(220); bus_cs_i = 1'b0;
    wait_cyc(225); bus_cs_i = 1'b1; bus_we_i = 1'b0; bus_oe_i = 1'b1;

    wait_cyc(232);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    if (sb.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule